// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a 16-bit EDO-style DRAM refreshed while an access sequencer owns the memory bus the rest of the time. An interval timer produces one refresh obligation per programmed period. Each obligation is held in a small saturating counter until the access sequencer grants the bus. The block then runs one refresh cycle on the strobes and releases the bus after a precharge gap.

Two refresh styles are available, chosen by a mode input. In the strobe-first style, the lower column strobe falls before the row strobe, so the device supplies its own row address; 4096 such cycles cover the array in one window. In the row-addressed style, the block drives a row taken from its own wrapping counter while the row strobe is low and both column strobes stay high; this style needs 8192 cycles per window. A low-power build doubles the window, which halves the refresh rate. The write-enable and output-enable lines stay high throughout, so the data pins are never driven during a refresh.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `ref_req` and `bus_own` are 0, `ras_n`, `cas_lo_n`, `cas_hi_n`, `we_n` and `oe_n` are 1, and `addr` is 0.
- R2: The timer raises one refresh obligation every CLK_KHZ*WINDOW_MS/ROWS cycles when `ras_only_mode`=1, and every CLK_KHZ*WINDOW_MS/(ROWS/2) cycles when it is 0. The mode is sampled each time the timer reloads. With the grant held high, successive refreshes start that many cycles apart.
- R3: With LOW_POWER=1, every interval is twice its LOW_POWER=0 value.
- R4: Unserved obligations accumulate up to PEND_MAX. Further obligations are dropped. After a long period without a grant, exactly PEND_MAX refreshes are then issued with one idle cycle between each pair.
- R5: `ref_req` rises two cycles after an obligation is registered and stays high until the refresh cycle ends. No strobe moves and `bus_own` stays 0 until `ref_gnt` has been seen high while `ref_req` is high.
- R6: A strobe-first refresh (`ras_only_mode`=0) holds `cas_lo_n`=0 with `ras_n`=1 for T_CSR cycles. It then holds `ras_n`=0 with `cas_lo_n` still 0 for T_RAS cycles. `cas_hi_n` stays 1 unless CBR_BOTH_CAS=1, and `addr` stays 0.
- R7: A row-addressed refresh (`ras_only_mode`=1) holds `ras_n`=0 for T_RAS cycles with both column strobes at 1 and the row counter value on `addr`.
- R8: The row counter starts at 0 and advances by one after each row-addressed refresh only, wrapping from 2**ROW_BITS-1 to 0.
- R9: After the row strobe rises, all strobes stay high with `bus_own`=1 for T_RP cycles. Then `bus_own` and `ref_req` fall together.
- R10: The refresh style is latched when the grant is taken. Changing `ras_only_mode` during a refresh cycle does not alter that cycle.
- R11: `we_n` and `oe_n` are 1 in every cycle, so the data pins stay high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | 1 selects row-addressed refresh, 0 selects strobe-first refresh |
| ref_gnt | input | 1 | Bus grant from the access sequencer |
| ref_req | output | 1 | Bus request to the access sequencer |
| bus_own | output | 1 | High while this block drives the strobes and address |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |
| addr | output | ROW_BITS | Row address during row-addressed refresh, else 0 |

## Verification
The assertions guard the invariants that hold in every cycle. The obligation count never exceeds its cap and is never decremented at zero. The row counter moves only in steps of one. The row strobe falls only while the bus is owned, and bus ownership starts only after a grant. A strobe-first row-strobe fall is preceded by the lower column strobe, and row-addressed cycles keep both column strobes high. The bus is released only from a fully precharged state. The exact refresh spacing, the doubled low-power spacing, the burst of deferred refreshes after a withheld grant, the row wrap and the mode being latched at the grant all depend on sequences of many cycles. Only the bench scenarios, compared against the cycle model, can show them.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_REQ,
    RS_SETUP,
    RS_ACTIVE,
    RS_PRECH
  } rfsh_state_e;

  // clock cycles between refresh obligations
  function automatic int unsigned rfsh_interval(input int unsigned clk_khz,
                                                input int unsigned window_ms,
                                                input int unsigned rows,
                                                input bit          low_power);
    int unsigned span;
    span = clk_khz * window_ms;
    if (low_power) span = span * 2;
    return span / rows;
  endfunction

  function automatic int unsigned rfsh_max3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned ROR_CYC = 1953,
  parameter int unsigned CBR_CYC = 3906
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_only,
  output logic tick
);
  localparam int unsigned CNT_W = $clog2(CBR_CYC + 1);
  localparam logic [CNT_W-1:0] RL_ROR = CNT_W'(ROR_CYC - 1);
  localparam logic [CNT_W-1:0] RL_CBR = CNT_W'(CBR_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  assign reload = ras_only ? RL_ROR : RL_CBR;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= reload;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= reload;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int unsigned PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic done,
  output logic pend_nz
);
  localparam int unsigned PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

  logic [PW-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else if (tick && !done) begin
      if (pend != CAP) pend <= pend + 1'b1;
    end else if (!tick && done) begin
      pend <= pend - 1'b1;
    end
  end

  assign pend_nz = (pend != '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    pend <= CAP);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> pend != '0);

endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int unsigned ROW_BITS = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  output logic [ROW_BITS-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (adv) row <= row + 1'b1;
  end

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (row != $past(row)) |-> (row == $past(row) + 1'b1));

endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
  import rfsh_pkg::*;
#(
  parameter int unsigned ROW_BITS     = 13,
  parameter int unsigned T_CSR        = 2,
  parameter int unsigned T_RAS        = 12,
  parameter int unsigned T_RP         = 8,
  parameter bit          CBR_BOTH_CAS = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pend_nz,
  input  logic                ras_only,
  input  logic                ref_gnt,
  input  logic [ROW_BITS-1:0] row,
  output logic                done,
  output logic                row_adv,
  output logic                ref_req,
  output logic                bus_own,
  output logic                ras_n,
  output logic                cas_lo_n,
  output logic                cas_hi_n,
  output logic [ROW_BITS-1:0] addr
);
  localparam int unsigned TW = $clog2(rfsh_max3(T_CSR, T_RAS, T_RP) + 1);
  localparam logic [TW-1:0] LD_CSR = TW'(T_CSR - 1);
  localparam logic [TW-1:0] LD_RAS = TW'(T_RAS - 1);
  localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 1);

  rfsh_state_e st, nxt;
  logic [TW-1:0] tcnt, tcnt_n;
  logic cbr_q, cbr_n;
  logic cas_lo_nx;

  always_comb begin
    nxt    = st;
    tcnt_n = tcnt;
    cbr_n  = cbr_q;
    done   = 1'b0;
    case (st)
      RS_IDLE: if (pend_nz) nxt = RS_REQ;
      RS_REQ: begin
        if (ref_gnt) begin
          cbr_n = !ras_only;
          if (ras_only) begin
            nxt    = RS_ACTIVE;
            tcnt_n = LD_RAS;
          end else begin
            nxt    = RS_SETUP;
            tcnt_n = LD_CSR;
          end
        end
      end
      RS_SETUP: begin
        if (tcnt == '0) begin
          nxt    = RS_ACTIVE;
          tcnt_n = LD_RAS;
        end else begin
          tcnt_n = tcnt - 1'b1;
        end
      end
      RS_ACTIVE: begin
        if (tcnt == '0) begin
          nxt    = RS_PRECH;
          tcnt_n = LD_RP;
        end else begin
          tcnt_n = tcnt - 1'b1;
        end
      end
      RS_PRECH: begin
        if (tcnt == '0) begin
          nxt  = RS_IDLE;
          done = 1'b1;
        end else begin
          tcnt_n = tcnt - 1'b1;
        end
      end
      default: nxt = RS_IDLE;
    endcase
  end

  assign row_adv   = done && !cbr_q;
  assign cas_lo_nx = !((nxt == RS_SETUP) || ((nxt == RS_ACTIVE) && cbr_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RS_IDLE;
      tcnt     <= '0;
      cbr_q    <= 1'b0;
      ref_req  <= 1'b0;
      bus_own  <= 1'b0;
      ras_n    <= 1'b1;
      cas_lo_n <= 1'b1;
      addr     <= '0;
    end else begin
      st       <= nxt;
      tcnt     <= tcnt_n;
      cbr_q    <= cbr_n;
      ref_req  <= (nxt != RS_IDLE);
      bus_own  <= (nxt == RS_SETUP) || (nxt == RS_ACTIVE) || (nxt == RS_PRECH);
      ras_n    <= (nxt != RS_ACTIVE);
      cas_lo_n <= cas_lo_nx;
      addr     <= ((nxt == RS_ACTIVE) && !cbr_n) ? row : '0;
    end
  end

  generate
    if (CBR_BOTH_CAS) begin : g_both_cas
      always_ff @(posedge clk) begin
        if (rst) cas_hi_n <= 1'b1;
        else     cas_hi_n <= cas_lo_nx;
      end
    end else begin : g_low_cas
      always_ff @(posedge clk) begin
        cas_hi_n <= 1'b1;
      end
    end
  endgenerate

  // R5
  own_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> $past(ref_gnt));

  // R5
  ras_needs_own_chk: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> bus_own && ref_req);

  // R6
  cbr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && cbr_q) |-> ($past(!cas_lo_n) && !cas_lo_n));

  // R7
  ror_cas_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && !cbr_q) |-> (cas_lo_n && cas_hi_n));

  // R9
  release_precharged_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_own) |-> $past(ras_n && cas_lo_n && cas_hi_n) && !ref_req);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 250000,
  parameter int unsigned WINDOW_MS    = 64,
  parameter int unsigned ROW_BITS     = 13,
  parameter bit          LOW_POWER    = 1'b0,
  parameter int unsigned PEND_MAX     = 3,
  parameter int unsigned T_CSR        = 2,
  parameter int unsigned T_RAS        = 12,
  parameter int unsigned T_RP         = 8,
  parameter bit          CBR_BOTH_CAS = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_only_mode,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                bus_own,
  output logic                ras_n,
  output logic                cas_lo_n,
  output logic                cas_hi_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [ROW_BITS-1:0] addr
);
  localparam int unsigned ROR_ROWS = 2 ** ROW_BITS;
  localparam int unsigned CBR_ROWS = ROR_ROWS / 2;
  localparam int unsigned ROR_CYC  = rfsh_interval(CLK_KHZ, WINDOW_MS, ROR_ROWS, LOW_POWER);
  localparam int unsigned CBR_CYC  = rfsh_interval(CLK_KHZ, WINDOW_MS, CBR_ROWS, LOW_POWER);

  logic                tick;
  logic                done;
  logic                pend_nz;
  logic                row_adv;
  logic [ROW_BITS-1:0] row;

  rfsh_interval_timer #(.ROR_CYC(ROR_CYC), .CBR_CYC(CBR_CYC)) u_timer (
    .clk(clk), .rst(rst), .ras_only(ras_only_mode), .tick(tick)
  );

  rfsh_pending #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst(rst), .tick(tick), .done(done), .pend_nz(pend_nz)
  );

  rfsh_row_counter #(.ROW_BITS(ROW_BITS)) u_row (
    .clk(clk), .rst(rst), .adv(row_adv), .row(row)
  );

  rfsh_cycle_fsm #(
    .ROW_BITS(ROW_BITS), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .CBR_BOTH_CAS(CBR_BOTH_CAS)
  ) u_fsm (
    .clk(clk), .rst(rst), .pend_nz(pend_nz), .ras_only(ras_only_mode),
    .ref_gnt(ref_gnt), .row(row), .done(done), .row_adv(row_adv),
    .ref_req(ref_req), .bus_own(bus_own), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .addr(addr)
  );

  // data pins stay high-impedance: no write, no output enable
  always_ff @(posedge clk) begin
    we_n <= 1'b1;
    oe_n <= 1'b1;
  end

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int RB    = 5;
  localparam int NROWS = 32;
  localparam int KHZ   = 8;
  localparam int WMS   = 64;
  localparam int R_ROR = KHZ * WMS / NROWS;        // 16
  localparam int R_CBR = KHZ * WMS / (NROWS / 2);  // 32
  localparam int TCSR  = 2;
  localparam int TRAS  = 4;
  localparam int TRP   = 3;
  localparam int PMAX  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b1;
  logic gnt = 1'b1;
  logic ref_req, bus_own, ras_n, cas_lo_n, cas_hi_n, we_n, oe_n;
  logic [RB-1:0] addr;
  logic lp_req, lp_own, lp_ras, lp_cl, lp_ch, lp_we, lp_oe;
  logic [RB-1:0] lp_addr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  dram_refresh_sched #(.CLK_KHZ(KHZ), .WINDOW_MS(WMS), .ROW_BITS(RB),
    .PEND_MAX(PMAX), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)) uut (
    .clk(clk), .rst(rst), .ras_only_mode(mode), .ref_gnt(gnt),
    .ref_req(ref_req), .bus_own(bus_own), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
    .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n), .addr(addr));

  dram_refresh_sched #(.CLK_KHZ(KHZ), .WINDOW_MS(WMS), .ROW_BITS(RB),
    .LOW_POWER(1'b1), .PEND_MAX(PMAX), .T_CSR(TCSR), .T_RAS(TRAS),
    .T_RP(TRP)) uut_lp (
    .clk(clk), .rst(rst), .ras_only_mode(1'b1), .ref_gnt(1'b0),
    .ref_req(lp_req), .bus_own(lp_own), .ras_n(lp_ras), .cas_lo_n(lp_cl),
    .cas_hi_n(lp_ch), .we_n(lp_we), .oe_n(lp_oe), .addr(lp_addr));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle,1 request,2 setup,3 active,4 precharge
  int m_tmr, m_pend, m_st, m_left, m_row;
  bit m_tick, m_cbr;
  bit e_req, e_own, e_ras, e_cl, e_addr_ok;
  int e_addr;

  always @(posedge clk) begin
    int nst, nleft, npend, ntmr;
    bit ntick, ncbr, dn;
    cyc++;
    if (rst) begin
      m_tmr = (mode ? R_ROR : R_CBR) - 1; m_tick = 0; m_pend = 0;
      m_st = 0; m_left = 0; m_row = 0; m_cbr = 0;
      e_req = 0; e_own = 0; e_ras = 1; e_cl = 1; e_addr = 0;
    end else begin
      dn = (m_st == 4) && (m_left == 0);
      npend = m_pend;
      if (m_tick && !dn && m_pend < PMAX) npend = m_pend + 1;
      else if (!m_tick && dn) npend = m_pend - 1;
      if (m_tmr == 0) begin ntmr = (mode ? R_ROR : R_CBR) - 1; ntick = 1; end
      else begin ntmr = m_tmr - 1; ntick = 0; end
      nst = m_st; nleft = m_left; ncbr = m_cbr;
      case (m_st)
        0: if (m_pend > 0) nst = 1;
        1: if (gnt) begin
             ncbr = !mode;
             if (mode) begin nst = 3; nleft = TRAS - 1; end
             else begin nst = 2; nleft = TCSR - 1; end
           end
        2: if (m_left == 0) begin nst = 3; nleft = TRAS - 1; end else nleft = m_left - 1;
        3: if (m_left == 0) begin nst = 4; nleft = TRP - 1; end else nleft = m_left - 1;
        default: if (m_left == 0) nst = 0; else nleft = m_left - 1;
      endcase
      e_req  = (nst != 0);
      e_own  = (nst >= 2);
      e_ras  = (nst != 3);
      e_cl   = !((nst == 2) || (nst == 3 && ncbr));
      e_addr = (nst == 3 && !ncbr) ? m_row : 0;
      if (dn && !m_cbr) m_row = (m_row + 1) % NROWS;
      m_tmr = ntmr; m_tick = ntick; m_pend = npend;
      m_st = nst; m_left = nleft; m_cbr = ncbr;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 ref_req", int'(ref_req), int'(e_req));
      chk("R9 bus_own", int'(bus_own), int'(e_own));
      chk("R6/R7 ras_n", int'(ras_n), int'(e_ras));
      chk("R6 cas_lo_n", int'(cas_lo_n), int'(e_cl));
      chk("R7 cas_hi_n", int'(cas_hi_n), 1);
      chk("R8 addr", int'(addr), e_addr);
      chk("R11 we_n", int'(we_n), 1);
      chk("R11 oe_n", int'(oe_n), 1);
    end
  end

  // observers for row-strobe falls
  logic ras_d = 1'b1;
  int falls = 0;
  int last_fall = 0;
  int gap = 0;
  always @(negedge clk) begin
    if (!rst && ras_d && !ras_n) begin
      falls++;
      gap = cyc - last_fall;
      last_fall = cyc;
    end
    ras_d = ras_n;
  end

  int lp_first = 0;
  int std_first = 0;
  always @(negedge clk) begin
    if (!rst && lp_req && lp_first == 0) lp_first = cyc;
    if (!rst && ref_req && std_first == 0) std_first = cyc;
  end

  int rst_cyc = 0;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int f0;
    int ror_idx;
    @(negedge clk);
    // R1: reset state while held
    chk("R1 ref_req", int'(ref_req), 0);
    chk("R1 ras_n", int'(ras_n), 1);
    chk("R1 cas_lo_n", int'(cas_lo_n), 1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rst_cyc = cyc;
    @(negedge clk);
    // R1: first cycle after reset
    chk("R1 bus_own", int'(bus_own), 0);
    chk("R1 addr", int'(addr), 0);
    chk("R1 we_n", int'(we_n), 1);

    // R7/R8: row-addressed refreshes, rows count up and wrap
    ror_idx = 0;
    while (ror_idx < NROWS + 4) begin
      @(negedge clk);
      if (!ras_n && ras_d == 1'b0 && falls == ror_idx + 1) begin
        chk("R8 row sequence", int'(addr), ror_idx % NROWS);
        if (ror_idx >= 2) chk("R2 row-addressed spacing", gap, R_ROR);
        ror_idx++;
      end
    end
    // R3: low-power interval doubled (first request = interval + 2)
    chk("R3 low-power first request", lp_first - rst_cyc, 2 * (std_first - rst_cyc - 2) + 2);

    // R2: strobe-first spacing
    mode = 1'b0;
    repeat (3 * R_CBR) @(negedge clk);
    f0 = falls;
    while (falls < f0 + 2) @(negedge clk);
    chk("R2 strobe-first spacing", gap, R_CBR);

    // R10: mode flipped during the setup phase does not alter the cycle
    while (!(bus_own && ras_n && !cas_lo_n)) @(negedge clk);
    mode = 1'b1;
    while (ras_n) @(negedge clk);
    chk("R10 latched style cas_lo_n", int'(cas_lo_n), 0);
    chk("R10 latched style addr", int'(addr), 0);
    @(negedge clk);
    mode = 1'b0;
    while (bus_own) @(negedge clk);

    // R4: withhold grant, then release
    while (ref_req) @(negedge clk);
    gnt = 1'b0;
    repeat (6 * R_CBR) @(negedge clk);
    chk("R5 no strobe without grant", int'(bus_own), 0);
    f0 = falls;
    gnt = 1'b1;
    repeat (34) @(negedge clk);
    chk("R4 deferred burst count", falls - f0, PMAX);
    repeat (16) @(negedge clk);
    tests++;
    if (falls - f0 > PMAX + 1) begin
      fails++;
      $display("FAIL R4 cap exceeded: got %0d expected <= %0d", falls - f0, PMAX + 1);
    end

    repeat (100) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule